// File: doc/BRIEF.md
# Packed pixel bitmap memory window

This block maps a 1 MB processor address window onto a byte-wide work RAM so that every window address names one small pixel field inside a RAM byte rather than a whole byte. Software can then read or write single 2-bit or 4-bit pixels at consecutive addresses, with no shifting or masking of its own. Only one bus master is connected to the window; arbitration with any other master and the other ways of reaching the same RAM sit outside this block.

A read returns the selected field right-aligned and zero-extended, one cycle after the request. A write turns into a read-modify-write of the RAM byte: the byte is read in the cycle the request is taken, and in the following cycle the merged byte goes back to the same address while the adapter stalls the processor. A one-bit mode register picks the pixel depth. The RAM size is a power of two given by a parameter, and byte addresses beyond it wrap.

Top module: `pixwin_top`

## Requirements
- R1: After reset the depth is 2-bit, and `bus_stall`, `bus_rvalid` and `ram_en` are low until a request arrives.
- R2: At 2-bit depth the RAM byte address is the window address shifted right by 2, keeping its low RAM_AW bits.
- R3: At 2-bit depth the field starts at bit 2*addr[1:0]; a read raises `bus_rvalid` in the next cycle with the field in `bus_rdata[1:0]` and all other bits zero.
- R4: At 4-bit depth the byte address is the window address shifted right by 1 (low RAM_AW bits), the field starts at bit 4*addr[0], and a read returns it in `bus_rdata[3:0]` with bits 7:4 zero.
- R5: A write reads the target byte in the cycle it is taken and writes the merged byte to the same address in the next cycle; bits outside the field are kept, the field takes the low 2 or 4 bits of `bus_wdata`, and the upper data bits are ignored.
- R6: `bus_stall` is high for exactly the write-back cycle of a write; a request presented while it is high is not taken and leaves RAM unchanged.
- R7: `mode_wr` loads `mode_4bpp` into the depth register (0 = 2-bit, 1 = 4-bit); a request in the same cycle still uses the previous depth, and later requests use the new one.
- R8: Window addresses whose byte address exceeds the RAM size alias onto the byte with the same low RAM_AW address bits, at both depths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Load the depth register |
| mode_4bpp | input | 1 | Depth value: 0 = 2-bit, 1 = 4-bit |
| bus_req | input | 1 | Window access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | WIN_AW | Window address |
| bus_wdata | input | 8 | Pixel value to write (low bits used) |
| bus_rdata | output | 8 | Extracted pixel, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid |
| bus_stall | output | 1 | Write-back cycle in progress; request not taken |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | RAM_AW | RAM byte address |
| ram_wdata | output | 8 | Byte written to RAM |
| ram_rdata | input | 8 | RAM read data, one cycle after a read |

## Verification
The bench targets the field position at every low-address value at both depths: a wrong shift would return a neighbouring pixel or corrupt it on write. It writes data with all upper bits set, which a missing mask would leak into neighbouring pixels, and it places a second request inside the stall cycle, which a design that took it would turn into an extra RAM access or a lost merge. It also flips the depth in the same cycle as a read, where a design using the new depth too early reads the wrong byte, and it drives addresses far above the RAM size, where a missing wrap would address the wrong byte.

// File: rtl/pixwin_pkg.sv
package pixwin_pkg;

  typedef enum logic {
    DEPTH2 = 1'b0,
    DEPTH4 = 1'b1
  } depth_e;

  // Bit position of the pixel field inside its byte
  function automatic logic [2:0] field_shift(depth_e d, logic [1:0] lo);
    return (d == DEPTH4) ? {lo[0], 2'b00} : {lo, 1'b0};
  endfunction

  // Right-aligned field mask for a depth
  function automatic logic [7:0] field_mask(depth_e d);
    return (d == DEPTH4) ? 8'h0F : 8'h03;
  endfunction

  // Pull the field out of a byte
  function automatic logic [7:0] field_get(logic [7:0] b, logic [2:0] sh,
                                           logic [7:0] mk);
    return (b >> sh) & mk;
  endfunction

  // Put new pixel bits into a byte, keeping the rest
  function automatic logic [7:0] field_put(logic [7:0] b, logic [7:0] px,
                                           logic [2:0] sh, logic [7:0] mk);
    return (b & ~(mk << sh)) | ((px & mk) << sh);
  endfunction

endpackage

// File: rtl/pixwin_map.sv
module pixwin_map
  import pixwin_pkg::*;
#(
  parameter int WIN_AW = 20,
  parameter int RAM_AW = 16
) (
  input  depth_e              depth,
  input  logic [WIN_AW-1:0]   win_addr,
  output logic [RAM_AW-1:0]   byte_addr,
  output logic [2:0]          shift,
  output logic [7:0]          mask
);

  localparam int HI2 = RAM_AW + 1;

  logic [RAM_AW-1:0] addr_d2;
  logic [RAM_AW-1:0] addr_d4;

  assign addr_d2 = win_addr[HI2:2];
  assign addr_d4 = win_addr[RAM_AW:1];

  // Window bits above the RAM range only alias
  generate
    if (HI2 + 1 < WIN_AW) begin : g_alias
      logic unused_alias;
      assign unused_alias = ^win_addr[WIN_AW-1:HI2+1];
    end
  endgenerate

  assign byte_addr = (depth == DEPTH4) ? addr_d4 : addr_d2;
  assign shift     = field_shift(depth, win_addr[1:0]);
  assign mask      = field_mask(depth);

endmodule

// File: rtl/pixwin_seq.sv
module pixwin_seq
  import pixwin_pkg::*;
#(
  parameter int RAM_AW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [RAM_AW-1:0] map_addr,
  input  logic [2:0]        map_shift,
  input  logic [7:0]        map_mask,
  input  logic [7:0]        wdata,
  input  logic [7:0]        ram_rdata,
  output logic              ram_en,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  output logic              stall,
  output logic              rvalid,
  output logic [7:0]        rdata
);

  typedef enum logic { ST_IDLE = 1'b0, ST_MERGE = 1'b1 } st_e;

  st_e               st;
  logic [RAM_AW-1:0] hold_addr;
  logic [2:0]        hold_shift;
  logic [7:0]        hold_mask;
  logic [7:0]        hold_data;
  logic              rd_pend;
  logic [2:0]        rd_shift;
  logic [7:0]        rd_mask;

  // Named events for the checks
  logic accept, rd_accept, wr_accept, in_merge;
  assign in_merge  = (st == ST_MERGE);
  assign accept    = req && !in_merge;
  assign rd_accept = accept && !we;
  assign wr_accept = accept && we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      hold_addr  <= '0;
      hold_shift <= '0;
      hold_mask  <= '0;
      hold_data  <= '0;
      rd_pend    <= 1'b0;
      rd_shift   <= '0;
      rd_mask    <= '0;
    end else begin
      rd_pend <= rd_accept;
      if (rd_accept) begin
        rd_shift <= map_shift;
        rd_mask  <= map_mask;
      end
      if (wr_accept) begin
        st         <= ST_MERGE;
        hold_addr  <= map_addr;
        hold_shift <= map_shift;
        hold_mask  <= map_mask;
        hold_data  <= wdata;
      end else begin
        st <= ST_IDLE;
      end
    end
  end

  always_comb begin
    if (in_merge) begin
      ram_en    = 1'b1;
      ram_we    = 1'b1;
      ram_addr  = hold_addr;
      ram_wdata = field_put(ram_rdata, hold_data, hold_shift, hold_mask);
    end else begin
      ram_en    = req;
      ram_we    = 1'b0;
      ram_addr  = map_addr;
      ram_wdata = '0;
    end
  end

  assign stall  = in_merge;
  assign rvalid = rd_pend;
  assign rdata  = rd_pend ? field_get(ram_rdata, rd_shift, rd_mask) : 8'h00;

  // R6
  stall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);

  // R5
  rmw_same_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_addr == $past(ram_addr)) && $past(ram_en && !ram_we));

  // R5
  keep_other_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> ((ram_wdata ^ ram_rdata) & ~(8'(hold_mask << hold_shift))) == 8'h00);

  // R3
  rvalid_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> $past(req && !we && !stall));

  // R3
  rdata_zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> (rdata & ~rd_mask) == 8'h00);

  // R6
  stall_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !rvalid);

endmodule

// File: rtl/pixwin_top.sv
module pixwin_top
  import pixwin_pkg::*;
#(
  parameter int WIN_AW = 20,
  parameter int RAM_AW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic              mode_4bpp,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [WIN_AW-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              bus_rvalid,
  output logic              bus_stall,
  output logic              ram_en,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  input  logic [7:0]        ram_rdata
);

  depth_e            mode_q;
  logic [RAM_AW-1:0] map_addr;
  logic [2:0]        map_shift;
  logic [7:0]        map_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= DEPTH2;
    else if (mode_wr) mode_q <= depth_e'(mode_4bpp);
  end

  pixwin_map #(.WIN_AW(WIN_AW), .RAM_AW(RAM_AW)) u_map (
    .depth     (mode_q),
    .win_addr  (bus_addr),
    .byte_addr (map_addr),
    .shift     (map_shift),
    .mask      (map_mask)
  );

  pixwin_seq #(.RAM_AW(RAM_AW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (bus_req),
    .we        (bus_we),
    .map_addr  (map_addr),
    .map_shift (map_shift),
    .map_mask  (map_mask),
    .wdata     (bus_wdata),
    .ram_rdata (ram_rdata),
    .ram_en    (ram_en),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata),
    .stall     (bus_stall),
    .rvalid    (bus_rvalid),
    .rdata     (bus_rdata)
  );

  // R7
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_wr |=> $stable(mode_q));

  // R4
  depth4_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rvalid && $past(mode_q == DEPTH4 && bus_req)) |-> bus_rdata[7:4] == 4'h0);

endmodule

// File: tb/pixwin_top_test.sv
module pixwin_top_test;

  localparam int WAW = 20;
  localparam int RAW = 10;
  localparam int RSZ = 1 << RAW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_wr = 1'b0, mode_4bpp = 1'b0;
  logic bus_req = 1'b0, bus_we = 1'b0;
  logic [WAW-1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic bus_rvalid, bus_stall, ram_en, ram_we;
  logic [RAW-1:0] ram_addr;
  logic [7:0] ram_wdata;
  logic [7:0] ram_rdata = '0;

  always #5 clk = ~clk;

  pixwin_top #(.WIN_AW(WAW), .RAM_AW(RAW)) uut (.*);

  // Environment RAM, one cycle read latency
  logic [7:0] ram_mem [RSZ];
  always @(posedge clk) begin
    if (ram_en) begin
      if (ram_we) ram_mem[ram_addr] <= ram_wdata;
      else        ram_rdata <= ram_mem[ram_addr];
    end
  end

  // Reference model state
  int ref_mem [RSZ];
  int m_depth;
  bit m_merge, m_rpend;
  int m_addr, m_sh, m_mk, m_data;
  int r_addr, r_sh, r_mk;
  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  function automatic void locate(int depth, int a, output int ba, output int sh,
                                 output int mk);
    if (depth == 0) begin
      ba = (a / 4) % RSZ; sh = (a % 4) * 2; mk = 3;
    end else begin
      ba = (a / 2) % RSZ; sh = (a % 2) * 4; mk = 15;
    end
  endfunction

  always @(posedge clk) begin
    int ba, sh, mk;
    if (!rst_n) begin
      m_depth = 0; m_merge = 0; m_rpend = 0;
    end else begin
      m_rpend = 0;
      if (m_merge) begin
        ref_mem[m_addr] = ((ref_mem[m_addr] / (1 << m_sh) & m_mk) == (m_data % (m_mk + 1)))
                          ? ref_mem[m_addr]
                          : (ref_mem[m_addr] - (ref_mem[m_addr] / (1 << m_sh) % (m_mk + 1)) * (1 << m_sh)
                             + (m_data % (m_mk + 1)) * (1 << m_sh));
        m_merge = 0;
      end else if (bus_req) begin
        locate(m_depth, int'(bus_addr), ba, sh, mk);
        if (bus_we) begin
          m_merge = 1; m_addr = ba; m_sh = sh; m_mk = mk; m_data = int'(bus_wdata);
        end else begin
          m_rpend = 1; r_addr = ba; r_sh = sh; r_mk = mk;
        end
      end
      if (mode_wr) m_depth = int'(mode_4bpp);
    end
  end

  // Per-cycle comparison, away from the active edge
  always begin
    int ba, sh, mk;
    int e_en, e_we, e_addr, e_wd, e_st, e_rv, e_rd;
    @(negedge clk); #3;
    e_en = 0; e_we = 0; e_addr = -1; e_wd = -1; e_st = 0;
    if (rst_n && m_merge) begin
      e_en = 1; e_we = 1; e_st = 1; e_addr = m_addr;
      e_wd = ref_mem[m_addr] - (ref_mem[m_addr] / (1 << m_sh) % (m_mk + 1)) * (1 << m_sh)
             + (m_data % (m_mk + 1)) * (1 << m_sh);
    end else if (bus_req) begin
      e_en = 1;
      locate(rst_n ? m_depth : 0, int'(bus_addr), ba, sh, mk);
      e_addr = ba;
    end
    e_rv = (rst_n && m_rpend) ? 1 : 0;
    e_rd = e_rv ? (ref_mem[r_addr] / (1 << r_sh)) % (r_mk + 1) : 0;
    n_cmp++;
    if (int'(ram_en) != e_en || int'(ram_we) != e_we || int'(bus_stall) != e_st ||
        int'(bus_rvalid) != e_rv || int'(bus_rdata) != e_rd ||
        (e_addr >= 0 && int'(ram_addr) != e_addr) || (e_wd >= 0 && int'(ram_wdata) != e_wd)) begin
      n_bad++;
      $display("FAIL %s t=%0t: en/we/st/rv=%0d%0d%0d%0d rd=%0h addr=%0h wd=%0h expected %0d%0d%0d%0d rd=%0h addr=%0h wd=%0h",
               cur_req, $time, ram_en, ram_we, bus_stall, bus_rvalid, bus_rdata, ram_addr, ram_wdata,
               e_en, e_we, e_st, e_rv, e_rd, e_addr, e_wd);
    end
  end

  task automatic cyc(input bit rq, input bit w, input int a, input int d,
                     input bit mw = 0, input bit mv = 0);
    @(negedge clk);
    bus_req = rq; bus_we = w; bus_addr = WAW'(a); bus_wdata = 8'(d);
    mode_wr = mw; mode_4bpp = mv;
  endtask

  task automatic rd(input int a); cyc(1, 0, a, 0); endtask
  task automatic wr(input int a, input int d); cyc(1, 1, a, d); cyc(0, 0, 0, 0); endtask
  task automatic idle(input int n); repeat (n) cyc(0, 0, 0, 0); endtask

  initial begin
    for (int i = 0; i < RSZ; i++) begin
      ram_mem[i] = 8'((i * 37 + 5) & 255);
      ref_mem[i] = (i * 37 + 5) & 255;
    end
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    cur_req = "R3";
    for (int a = 0; a < 8; a++) rd(a);
    idle(1);

    cur_req = "R2";
    rd(12'h100); rd(13'h1235); rd(16'h1FFC);
    idle(1);

    cur_req = "R5";
    wr(6, 8'hFF); rd(6); rd(5); rd(7);
    wr(9, 8'hFC); wr(10, 8'h01); rd(9); rd(10);
    idle(1);

    cur_req = "R6";
    cyc(1, 1, 20, 8'h02);
    cyc(1, 1, 21, 8'h03);
    cyc(0, 0, 0, 0);
    rd(21); rd(20);
    cyc(1, 1, 22, 8'h01); cyc(1, 0, 22, 0); rd(22);
    idle(1);

    cur_req = "R7";
    cyc(1, 0, 3, 0, 1, 1);
    rd(3); rd(2);
    idle(1);

    cur_req = "R4";
    for (int a = 40; a < 44; a++) rd(a);
    wr(41, 8'hF5); rd(41); rd(40);
    wr(40, 8'h3C); rd(40); rd(41);
    idle(1);

    cur_req = "R8";
    rd(20'hFFFFF); wr(20'h80801, 8'h09); rd(1); rd(20'h00801);
    cyc(1, 0, 20'h00804, 0, 1, 0);
    rd(20'hFF004); wr(20'hFF006, 8'h02); rd(6);
    idle(1);

    cur_req = "R5";
    for (int i = 0; i < 400; i++) begin
      int k = int'($urandom_range(0, 9));
      if (k == 0) cyc(0, 0, 0, 0, 1, 1'($urandom_range(0, 1)));
      else cyc(1'($urandom_range(0, 3) != 0), 1'(k > 5),
               int'($urandom_range(0, 20'hFFFFF)), int'($urandom_range(0, 255)));
    end
    idle(3);

    cur_req = "R5";
    for (int i = 0; i < RSZ; i++) begin
      n_cmp++;
      if (int'(ram_mem[i]) != ref_mem[i]) begin
        n_bad++;
        $display("FAIL R5 ram[%0d]=%0h expected %0h", i, ram_mem[i], ref_mem[i]);
      end
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog %s: run did not end, expected completion", cur_req);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule